// File: doc/BRIEF.md
# Transmit Descriptor Ring Scanner

The block is a DMA engine that sends frames queued by a host in a 16-entry descriptor ring in memory. A kick pulse starts one scan while the block is running. The scan starts at the current transmit pointer and tests the flags byte of each descriptor. A descriptor that the host has handed over as a complete frame is decoded. Its buffer is then read and put out as a byte stream, and the last byte of the frame is marked. Ownership of the descriptor goes back to the host, the pointer advances, and a one-cycle transmit-interrupt pulse is raised. One scan can send several frames.

Each descriptor takes 8 bytes, and entry `i` starts at `ring_base + 8*i`. Offsets 0 and 1 hold the low 16 bits of the buffer address, most significant byte first. Offset 2 holds the flags byte and offset 3 holds bits 23:16 of the buffer address. Offsets 4 and 5 hold the frame length, most significant byte first, stored as the two's complement of the byte count. Offsets 6 and 7 are never read. Memory is reached one byte at a time through a request/acknowledge port. A request stays asserted with a stable address until the acknowledge arrives, and read data is valid in the acknowledge cycle.

Top module: `txring_scanner`

## Requirements
- R1: After reset, `busy`, `tx_valid`, `tx_last`, `tint` and `mem_req` are 0 and `tx_ptr` is 0.
- R2: A kick while `run` is low starts no scan: `busy` stays low and no memory access is made.
- R3: A descriptor is sent only when its flags byte (offset 2) equals exactly 0x83 (bit 7 host-handed, bit 1 frame start, bit 0 frame end). Any other value is skipped, and its flags byte is left unchanged.
- R4: The byte count is the 16-bit negation of the stored length. The bytes are read from consecutive addresses that start at `{addr[23:16], addr[15:0]}` and appear on `tx_data` in address order with `tx_valid`. `tx_last` is high only with the final byte.
- R5: A byte count above 1544 is limited to 1544. A count of 0 puts out no bytes, but the descriptor is still handed back.
- R6: After each sent frame, the value 0x03 is written to the frame's flags byte. `tx_ptr` then advances by one modulo 16, and `tint` pulses for exactly one cycle.
- R7: A scan starts at the entry equal to `tx_ptr` at the kick. It visits the following entries in order, with wrap modulo 16, and ends before the entry at that starting value minus one, which is never visited.
- R8: A kick that arrives while `busy` is high is ignored. No second scan follows.
- R9: `busy` rises in the cycle after an accepted kick and stays high until the scan ends. While `mem_req` waits for `mem_ack`, the address, the write enable and the write data do not change.
- R10: Descriptor entry `i` is read at `ring_base + 8*i`, so entries that wrap past 15 come back to the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | AW | Byte address of descriptor entry 0 |
| run | input | 1 | High when the controller runs; low blocks new scans |
| kick | input | 1 | Pulse that requests a ring scan |
| busy | output | 1 | High while a scan is in progress |
| tx_ptr | output | 4 | Transmit pointer, advanced per sent frame |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 8 | Read data |
| tx_valid | output | 1 | Frame byte valid |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| tint | output | 1 | One-cycle transmit interrupt pulse |

## Verification
A wrong scan index or stop bound shows up at the ports in the scan that meets it. The excluded entry gets sent, or an eligible entry stays unsent with its flags at 0x83. A wrong pointer shows up at `tx_ptr` right after the `tint` pulse. Bad length or address decoding is visible in the byte count and the data of the frame's stream before the hand-back write. The bench therefore checks the memory image, the byte stream and the pointer after every scan.

// File: rtl/txring_pkg.sv
package txring_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FLAGS,
        ST_LEN_HI,
        ST_LEN_LO,
        ST_ADR_TOP,
        ST_ADR_HI,
        ST_ADR_LO,
        ST_STREAM,
        ST_HANDBACK,
        ST_NEXT
    } scan_state_e;

    // byte offsets inside one descriptor
    localparam logic [2:0] OFS_ADR_HI  = 3'd0;
    localparam logic [2:0] OFS_ADR_LO  = 3'd1;
    localparam logic [2:0] OFS_FLAGS   = 3'd2;
    localparam logic [2:0] OFS_ADR_TOP = 3'd3;
    localparam logic [2:0] OFS_LEN_HI  = 3'd4;
    localparam logic [2:0] OFS_LEN_LO  = 3'd5;

    localparam logic [7:0] FLAGS_READY = 8'h83;
    localparam logic [7:0] FLAGS_DONE  = 8'h03;

endpackage

// File: rtl/txring_desc_addr.sv
module txring_desc_addr #(
    parameter int AW       = 24,
    parameter int RING_LOG = 4
) (
    input  logic [AW-1:0]       base,
    input  logic [RING_LOG-1:0] idx,
    input  logic [2:0]          ofs,
    output logic [AW-1:0]       addr
);
    localparam int SPAN = RING_LOG + 3;

    logic [SPAN-1:0] rel;

    always_comb begin
        rel  = {idx, ofs};
        addr = base + AW'(rel);
    end
endmodule

// File: rtl/txring_len_conv.sv
module txring_len_conv #(
    parameter int MAX_BYTES = 1544,
    parameter int CW        = $clog2(MAX_BYTES + 1)
) (
    input  logic [15:0]   stored,
    output logic [CW-1:0] count
);
    localparam logic [15:0] LIMIT = 16'(MAX_BYTES);

    logic [15:0] neg;

    always_comb begin
        neg = ~stored + 16'd1;
        if (neg > LIMIT) count = CW'(MAX_BYTES);
        else             count = neg[CW-1:0];
    end

    always_comb begin
        assert (count <= CW'(MAX_BYTES))
            else $error("a_r5_count_limit: count %0d above cap", count);
    end
endmodule

// File: rtl/txring_scanner.sv
module txring_scanner
    import txring_pkg::*;
#(
    parameter int AW        = 24,
    parameter int RING_LOG  = 4,
    parameter int MAX_BYTES = 1544
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       ring_base,
    input  logic                run,
    input  logic                kick,
    output logic                busy,
    output logic [RING_LOG-1:0] tx_ptr,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [7:0]          mem_wdata,
    input  logic                mem_ack,
    input  logic [7:0]          mem_rdata,
    output logic                tx_valid,
    output logic [7:0]          tx_data,
    output logic                tx_last,
    output logic                tint
);
    localparam int CW = $clog2(MAX_BYTES + 1);
    localparam int BW = 24;

    typedef struct packed {
        scan_state_e         state;
        logic [RING_LOG-1:0] idx;
        logic [RING_LOG-1:0] stop;
        logic [RING_LOG-1:0] ptr;
        logic [15:0]         len;
        logic [BW-1:0]       bufa;
        logic [CW-1:0]       cnt;
        logic [CW-1:0]       pos;
        logic                tv;
        logic [7:0]          td;
        logic                tl;
        logic                tint;
    } scan_t;

    scan_t s_q, s_d;

    logic [2:0]    ofs;
    logic [AW-1:0] desc_addr;
    logic [CW-1:0] count;

    txring_desc_addr #(.AW(AW), .RING_LOG(RING_LOG)) u_desc_addr (
        .base (ring_base),
        .idx  (s_q.idx),
        .ofs  (ofs),
        .addr (desc_addr)
    );

    txring_len_conv #(.MAX_BYTES(MAX_BYTES), .CW(CW)) u_len_conv (
        .stored (s_q.len),
        .count  (count)
    );

    always_comb begin
        s_d       = s_q;
        s_d.tv    = 1'b0;
        s_d.tl    = 1'b0;
        s_d.tint  = 1'b0;
        ofs       = OFS_FLAGS;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = FLAGS_DONE;
        mem_addr  = desc_addr;

        unique case (s_q.state)
            ST_IDLE: begin
                if (kick && run) begin
                    s_d.idx   = s_q.ptr;
                    s_d.stop  = s_q.ptr - 1'b1;
                    s_d.state = ST_FLAGS;
                end
            end
            ST_FLAGS: begin
                mem_req = 1'b1;
                if (mem_ack)
                    s_d.state = (mem_rdata == FLAGS_READY) ? ST_LEN_HI : ST_NEXT;
            end
            ST_LEN_HI: begin
                ofs     = OFS_LEN_HI;
                mem_req = 1'b1;
                if (mem_ack) begin
                    s_d.len[15:8] = mem_rdata;
                    s_d.state     = ST_LEN_LO;
                end
            end
            ST_LEN_LO: begin
                ofs     = OFS_LEN_LO;
                mem_req = 1'b1;
                if (mem_ack) begin
                    s_d.len[7:0] = mem_rdata;
                    s_d.state    = ST_ADR_TOP;
                end
            end
            ST_ADR_TOP: begin
                ofs     = OFS_ADR_TOP;
                mem_req = 1'b1;
                if (mem_ack) begin
                    s_d.bufa[23:16] = mem_rdata;
                    s_d.state       = ST_ADR_HI;
                end
            end
            ST_ADR_HI: begin
                ofs     = OFS_ADR_HI;
                mem_req = 1'b1;
                if (mem_ack) begin
                    s_d.bufa[15:8] = mem_rdata;
                    s_d.state      = ST_ADR_LO;
                end
            end
            ST_ADR_LO: begin
                ofs     = OFS_ADR_LO;
                mem_req = 1'b1;
                if (mem_ack) begin
                    s_d.bufa[7:0] = mem_rdata;
                    s_d.cnt       = count;
                    s_d.pos       = '0;
                    s_d.state     = (count == '0) ? ST_HANDBACK : ST_STREAM;
                end
            end
            ST_STREAM: begin
                mem_req  = 1'b1;
                mem_addr = AW'(s_q.bufa) + AW'(s_q.pos);
                if (mem_ack) begin
                    s_d.tv  = 1'b1;
                    s_d.td  = mem_rdata;
                    s_d.tl  = (s_q.pos == s_q.cnt - 1'b1);
                    s_d.pos = s_q.pos + 1'b1;
                    if (s_q.pos == s_q.cnt - 1'b1) s_d.state = ST_HANDBACK;
                end
            end
            ST_HANDBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    s_d.ptr   = s_q.ptr + 1'b1;
                    s_d.tint  = 1'b1;
                    s_d.state = ST_NEXT;
                end
            end
            ST_NEXT: begin
                if (s_q.idx + 1'b1 == s_q.stop) begin
                    s_d.state = ST_IDLE;
                end else begin
                    s_d.idx   = s_q.idx + 1'b1;
                    s_d.state = ST_FLAGS;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{state: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign busy     = (s_q.state != ST_IDLE);
    assign tx_ptr   = s_q.ptr;
    assign tx_valid = s_q.tv;
    assign tx_data  = s_q.td;
    assign tx_last  = s_q.tl;
    assign tint     = s_q.tint;

    // R1 / R2: no memory traffic outside a scan
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);
    a_r2_stopped_no_scan: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !busy) |=> !busy);
    // R9: request held stable until acknowledged
    a_r9_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));
    // R4: last marker only on a valid byte
    a_r4_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);
    // R6: single-cycle interrupt, pointer steps only with it
    a_r6_tint_single: assert property (@(posedge clk) disable iff (!rst_n)
        tint |=> !tint);
    a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        tint |-> (tx_ptr == $past(tx_ptr) + 1'b1));
    a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tint |-> $stable(tx_ptr));
    // R6: the only write is the hand-back value
    a_r6_write_value: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata == FLAGS_DONE));
endmodule

// File: tb/txring_scanner_tb.sv
module txring_scanner_tb;
    localparam int AW   = 24;
    localparam int BASE = 'h100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ring_base = AW'(BASE);
    logic          run = 1'b0;
    logic          kick = 1'b0;
    logic          busy;
    logic [3:0]    tx_ptr;
    logic          mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, mem_rdata;
    logic          tx_valid, tx_last, tint;
    logic [7:0]    tx_data;

    always #2 clk = ~clk;

    txring_scanner u_dut (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .run(run), .kick(kick),
        .busy(busy), .tx_ptr(tx_ptr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tint(tint)
    );

    logic [7:0] mem [0:4095];
    logic       ack_r = 1'b0;
    logic [7:0] rd_r = 8'h00;
    assign mem_ack   = ack_r;
    assign mem_rdata = rd_r;

    always @(posedge clk) begin
        if (!rst_n) begin
            ack_r <= 1'b0;
        end else begin
            ack_r <= 1'b0;
            if (mem_req && !ack_r) begin
                ack_r <= 1'b1;
                if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
                else        rd_r <= mem[mem_addr[11:0]];
            end
        end
    end

    int checks = 0, fails = 0;
    int n_bytes = 0, n_tint = 0, n_starts = 0, n_acc = 0, n_last = 0;
    logic [7:0] got [0:2047];
    logic       got_last [0:2047];
    logic       busy_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid) begin
                got[n_bytes]      = tx_data;
                got_last[n_bytes] = tx_last;
                n_bytes++;
            end
            if (tx_last) n_last++;
            if (tint) n_tint++;
            if (mem_req && mem_ack) n_acc++;
            if (busy && !busy_prev) n_starts++;
            busy_prev = busy;
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_bytes = 0; n_tint = 0; n_starts = 0; n_acc = 0; n_last = 0;
    endtask

    task automatic put_desc(input int i, input logic [7:0] flags, input int nbytes, input int buf_a);
        int d;
        logic [15:0] l;
        d = BASE + 8 * i;
        l = 16'(-nbytes);
        mem[d]   = 8'(buf_a >> 8);
        mem[d+1] = 8'(buf_a);
        mem[d+2] = flags;
        mem[d+3] = 8'(buf_a >> 16);
        mem[d+4] = l[15:8];
        mem[d+5] = l[7:0];
    endtask

    function automatic logic [7:0] flags_of(input int i);
        return mem[BASE + 8 * i + 2];
    endfunction

    task automatic clear_ring();
        for (int i = 0; i < 16; i++) mem[BASE + 8 * i + 2] = 8'h00;
    endtask

    task automatic do_kick();
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_frame(input int start, input int buf_a, input int len, input string req);
        bit ok = 1;
        for (int k = 0; k < len; k++) begin
            if (got[start + k] !== pat(buf_a + k)) ok = 0;
            if (got_last[start + k] !== (k == len - 1)) ok = 0;
        end
        chk(ok, req, ok, 1);
    endtask

    task automatic t_reset();
        chk(!busy && !tx_valid && !tx_last && !tint && !mem_req, "R1 outputs idle", busy, 0);
        chk(tx_ptr == 0, "R1 pointer", tx_ptr, 0);
    endtask

    task automatic t_stopped();
        clear_counts();
        put_desc(0, 8'h83, 5, 'h200);
        run = 1'b0;
        do_kick();
        repeat (20) @(negedge clk);
        chk(n_starts == 0, "R2 no scan while stopped", n_starts, 0);
        chk(n_acc == 0, "R2 no memory access", n_acc, 0);
    endtask

    task automatic t_single();
        clear_counts();
        run = 1'b1;
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
        chk(busy, "R9 busy after kick", busy, 1);
        wait_idle();
        chk(n_bytes == 5, "R4 byte count", n_bytes, 5);
        check_frame(0, 'h200, 5, "R4 data and last marker");
        chk(flags_of(0) == 8'h03, "R6 hand-back value", flags_of(0), 3);
        chk(n_tint == 1, "R6 one interrupt", n_tint, 1);
        chk(tx_ptr == 1, "R6 pointer advance", tx_ptr, 1);
    endtask

    task automatic t_skip();
        clear_counts();
        clear_ring();
        put_desc(1, 8'h80, 4, 'h300);
        put_desc(2, 8'h82, 4, 'h300);
        put_desc(3, 8'h03, 4, 'h300);
        put_desc(4, 8'hC3, 4, 'h300);
        put_desc(5, 8'h83, 6, 'h340);
        do_kick();
        wait_idle();
        chk(n_bytes == 6 && n_tint == 1, "R3 only exact flags sent", n_bytes, 6);
        check_frame(0, 'h340, 6, "R3 sent frame data");
        chk(flags_of(1) == 8'h80 && flags_of(2) == 8'h82 && flags_of(3) == 8'h03
            && flags_of(4) == 8'hC3, "R3 skipped flags unchanged", flags_of(4), 'hC3);
        chk(tx_ptr == 2, "R6 pointer after skip scan", tx_ptr, 2);
    endtask

    task automatic t_wrap();
        clear_counts();
        clear_ring();
        put_desc(6, 8'h83, 3, 'h400);
        put_desc(7, 8'h83, 4, 'h440);
        put_desc(0, 8'h83, 2, 'h480);
        put_desc(1, 8'h83, 7, 'h4C0);
        do_kick();
        wait_idle();
        chk(n_tint == 3, "R7 several frames in one scan", n_tint, 3);
        chk(n_bytes == 9, "R7 total bytes", n_bytes, 9);
        check_frame(0, 'h400, 3, "R7 order entry 6");
        check_frame(3, 'h440, 4, "R7 order entry 7");
        check_frame(7, 'h480, 2, "R10 wrapped entry 0");
        chk(flags_of(1) == 8'h83, "R7 entry before start not visited", flags_of(1), 'h83);
        chk(tx_ptr == 5, "R7 pointer after scan", tx_ptr, 5);
    endtask

    task automatic t_cap_zero();
        clear_counts();
        clear_ring();
        put_desc(5, 8'h83, 2000, 'h200);
        put_desc(6, 8'h83, 0, 'hA00);
        do_kick();
        wait_idle();
        chk(n_bytes == 1544, "R5 length capped", n_bytes, 1544);
        chk(n_last == 1 && got_last[1543], "R5 single last marker", n_last, 1);
        chk(got[0] == pat('h200) && got[1543] == pat('h200 + 1543), "R5 capped data", got[1543], pat('h200 + 1543));
        chk(flags_of(6) == 8'h03 && n_tint == 2, "R5 zero length handed back", n_tint, 2);
        chk(tx_ptr == 7, "R5 pointer", tx_ptr, 7);
    endtask

    task automatic t_kick_busy();
        clear_counts();
        clear_ring();
        put_desc(7, 8'h83, 20, 'h600);
        do_kick();
        repeat (5) @(negedge clk);
        kick = 1'b1; @(negedge clk); kick = 1'b0;
        repeat (7) @(negedge clk);
        kick = 1'b1; @(negedge clk); kick = 1'b0;
        wait_idle();
        repeat (10) @(negedge clk);
        chk(n_starts == 1, "R8 kick during scan ignored", n_starts, 1);
        chk(!busy && n_tint == 1 && tx_ptr == 8, "R8 single frame", tx_ptr, 8);
    endtask

    initial begin
        for (int a = 0; a < 4096; a++) mem[a] = pat(a);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stopped();
        t_single();
        t_skip();
        t_wrap();
        t_cap_zero();
        t_kick_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule